// File: doc/BRIEF.md
# Accumulator Barrel Shifter Unit

This block executes the shift operations on a pair of 40-bit accumulators. It receives an already decoded 16-bit opcode together with the current values of both accumulators. It then returns the shifted value, the accumulator that value belongs in, and a zero flag and a sign flag taken from that value. Results are registered, so a write-back appears one clock after the opcode is presented.

There are three families of shift:

- **Fixed shifts.** These move an accumulator by exactly 16 positions.
- **Immediate shifts.** These take the count from a 6-bit field in the opcode. For the right-going forms, the field holds the negated count.
- **Register-driven shifts.** These take a signed count from the middle word (bits 31:16) of an accumulator. A negative count reverses the direction of the shift.

Logical right shifts fill with zeros from bit 39. Arithmetic right shifts copy bit 39. Any count of 40 or more saturates the result: all zeros, or a full sign fill for an arithmetic right shift.

Top module: `acc_shift_unit`

## Requirements
- R1: While rst_n is low, and after reset until the first accepted opcode, wr_valid, wr_sel, wr_data, flag_zero and flag_sign are all 0.
- R2: Opcode bits 15:9 = 0001010 select an immediate shift of accumulator opcode[8] (0 = ac0, 1 = ac1). Bits 7:6 select the operation (00 logical left, 01 logical right, 10 arithmetic left, 11 arithmetic right). For 00 and 10, the value is shifted left by the unsigned count in bits 5:0, with zeros entering at bit 0.
- R3: For immediate operations 01 and 11, the count is n = -(bits 5:0 read as signed 6-bit). If n >= 0, the shift is right by n: 01 fills with zeros, 11 copies bit 39. If n < 0, the value is shifted left by -n.
- R4: The fixed shifts move the value by 16 positions. Opcode[15:9] = 1111000 is a logical left shift of accumulator opcode[8]. Opcode[15:9] = 1111010 is a logical right shift of accumulator opcode[8]. Opcode[15:12] = 1001 with opcode[10:8] = 001 is an arithmetic right shift of accumulator opcode[11].
- R5: Opcode 0x02CA shifts ac0 by s, the signed 16-bit value in ac1 bits 31:16, as a logical right shift; 0x02CB does the same as an arithmetic right shift. When s < 0 the value is shifted left by -s, and when s = 0 it is returned unchanged. The result always goes to ac0.
- R6: Opcode[15:9] = 0011110 with opcode[7:0] = 0xC0 shifts ac1 by s, the signed value in ac0 bits 31:16. When s > 0 the shift is left by s; when s < 0 it is a logical right shift by -s. The result always goes to ac1, whatever the value of opcode[8].
- R7: A count of 40 or more gives 0 for left and logical right shifts, and 40 copies of bit 39 for an arithmetic right shift.
- R8: On a write-back, flag_zero is 1 exactly when wr_data is 0, and flag_sign equals wr_data[39].
- R9: An accepted opcode (op_valid high with a recognised encoding) sampled at one rising edge sets, after that same edge, wr_valid = 1, wr_sel to the destination accumulator (0 = ac0, 1 = ac1), and wr_data and the flags to its result.
- R10: When op_valid is low, or the opcode matches none of the forms above, the next cycle has wr_valid = 0, and wr_sel, wr_data and both flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode and accumulator inputs are valid this cycle |
| opcode | input | 16 | Decoded instruction word |
| acc0_in | input | 40 | Current value of accumulator 0 |
| acc1_in | input | 40 | Current value of accumulator 1 |
| wr_valid | output | 1 | A result is being written back this cycle |
| wr_sel | output | 1 | Destination accumulator of the result |
| wr_data | output | 40 | Shifted 40-bit result |
| flag_zero | output | 1 | Result is zero |
| flag_sign | output | 1 | Bit 39 of the result |

## Verification
The bench aims at the negated immediate field at its extremes. A field of 0x20 must give a right shift by 32, and a field of 0x01 must turn a right shift into a left shift by 1; a design that skips the negation shifts the wrong way and by the wrong count. Register-driven counts of 0, ±39, ±40 and -32768 check that zero returns the value unchanged and that saturation fills correctly. A wrong fill shows up as stray ones from bit 39 in a logical right shift, or as zeros where an arithmetic right shift should sign-fill. Ignored cycles and unknown opcodes are checked to hold every output, and the ac1-destination form is driven with both values of opcode[8] to catch a destination taken from that bit.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;
    localparam int ACC_W  = 40;
    localparam int WORD_W = 16;
    localparam int IMM_W  = 6;
    localparam int MAG_W  = WORD_W + 1;
    localparam int MID_LO = 16;

    typedef struct packed {
        logic             hit;
        logic             dst;
        logic             left;
        logic             arith;
        logic [MAG_W-1:0] mag;
    } shift_req_t;

    typedef struct packed {
        logic             wr_valid;
        logic             wr_sel;
        logic [ACC_W-1:0] wr_data;
        logic             fz;
        logic             fs;
    } out_state_t;
endpackage

// File: rtl/acc_shift_decode.sv
module acc_shift_decode
    import acc_shift_pkg::*;
#(
    parameter int OPC_W = 16
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [WORD_W-1:0] mid0,
    input  logic [WORD_W-1:0] mid1,
    output shift_req_t        req
);
    localparam logic [6:0] IMM_TAG  = 7'b0001010;
    localparam logic [6:0] L16_TAG  = 7'b1111000;
    localparam logic [6:0] R16_TAG  = 7'b1111010;
    localparam logic [6:0] REV_TAG  = 7'b0011110;
    localparam logic [OPC_W-1:0] LREG_OP = 16'h02CA;
    localparam logic [OPC_W-1:0] AREG_OP = 16'h02CB;

    logic [MAG_W-1:0] imm_amt;
    logic [MAG_W-1:0] amt_m1;
    logic [MAG_W-1:0] amt_m0;

    function automatic logic [MAG_W-1:0] magnitude(input logic [MAG_W-1:0] v);
        return v[MAG_W-1] ? (~v + 1'b1) : v;
    endfunction

    always_comb begin
        imm_amt = ~{{(MAG_W-IMM_W){opcode[IMM_W-1]}}, opcode[IMM_W-1:0]} + 1'b1;
        amt_m1  = {mid1[WORD_W-1], mid1};
        amt_m0  = {mid0[WORD_W-1], mid0};
        req     = '0;
        if (opcode[15:9] == IMM_TAG) begin
            req.hit = 1'b1;
            req.dst = opcode[8];
            if (!opcode[6]) begin
                req.left = 1'b1;
                req.mag  = {{(MAG_W-IMM_W){1'b0}}, opcode[IMM_W-1:0]};
            end else begin
                req.left  = imm_amt[MAG_W-1];
                req.arith = opcode[7];
                req.mag   = magnitude(imm_amt);
            end
        end else if (opcode[15:9] == L16_TAG) begin
            req.hit  = 1'b1;
            req.dst  = opcode[8];
            req.left = 1'b1;
            req.mag  = MAG_W'(16);
        end else if (opcode[15:9] == R16_TAG) begin
            req.hit = 1'b1;
            req.dst = opcode[8];
            req.mag = MAG_W'(16);
        end else if (opcode[15:12] == 4'b1001 && opcode[10:8] == 3'b001) begin
            req.hit   = 1'b1;
            req.dst   = opcode[11];
            req.arith = 1'b1;
            req.mag   = MAG_W'(16);
        end else if (opcode == LREG_OP || opcode == AREG_OP) begin
            req.hit   = 1'b1;
            req.dst   = 1'b0;
            req.arith = opcode[0];
            req.left  = amt_m1[MAG_W-1];
            req.mag   = magnitude(amt_m1);
        end else if (opcode[15:9] == REV_TAG && opcode[7:0] == 8'hC0) begin
            req.hit  = 1'b1;
            req.dst  = 1'b1;
            req.left = !amt_m0[MAG_W-1] && (amt_m0 != '0);
            req.mag  = magnitude(amt_m0);
        end
    end
endmodule

// File: rtl/acc_shift_core.sv
module acc_shift_core
    import acc_shift_pkg::*;
#(
    parameter int DW = ACC_W,
    parameter int MW = MAG_W
) (
    input  logic [DW-1:0] src,
    input  logic          left,
    input  logic          arith,
    input  logic [MW-1:0] mag,
    output logic [DW-1:0] res
);
    localparam int SH_W = $clog2(DW);

    logic          fill;
    logic          sat;
    logic [DW-1:0] stg [0:SH_W];

    assign fill   = arith & ~left & src[DW-1];
    assign sat    = (mag >= MW'(DW));
    assign stg[0] = src;

    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        localparam int D = 1 << i;
        if (D < DW) begin : g_shift
            assign stg[i+1] = !mag[i] ? stg[i] :
                              left    ? {stg[i][DW-1-D:0], {D{1'b0}}} :
                                        {{D{fill}}, stg[i][DW-1:D]};
        end else begin : g_pass
            assign stg[i+1] = stg[i];
        end
    end

    assign res = sat ? {DW{fill}} : stg[SH_W];
endmodule

// File: rtl/acc_shift_flags.sv
module acc_shift_flags
    import acc_shift_pkg::*;
#(
    parameter int DW = ACC_W
) (
    input  logic [DW-1:0] value,
    output logic          zero,
    output logic          sign
);
    assign zero = (value == '0);
    assign sign = value[DW-1];
endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
    import acc_shift_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [15:0]      opcode,
    input  logic [ACC_W-1:0] acc0_in,
    input  logic [ACC_W-1:0] acc1_in,
    output logic             wr_valid,
    output logic             wr_sel,
    output logic [ACC_W-1:0] wr_data,
    output logic             flag_zero,
    output logic             flag_sign
);
    shift_req_t       req;
    logic [ACC_W-1:0] src;
    logic [ACC_W-1:0] res;
    logic             res_z;
    logic             res_s;
    out_state_t       state_d;
    out_state_t       state_q;

    acc_shift_decode #(.OPC_W(16)) u_dec (
        .opcode (opcode),
        .mid0   (acc0_in[MID_LO +: WORD_W]),
        .mid1   (acc1_in[MID_LO +: WORD_W]),
        .req    (req)
    );

    assign src = req.dst ? acc1_in : acc0_in;

    acc_shift_core #(.DW(ACC_W), .MW(MAG_W)) u_core (
        .src   (src),
        .left  (req.left),
        .arith (req.arith),
        .mag   (req.mag),
        .res   (res)
    );

    acc_shift_flags #(.DW(ACC_W)) u_flags (
        .value (res),
        .zero  (res_z),
        .sign  (res_s)
    );

    always_comb begin
        state_d          = state_q;
        state_d.wr_valid = 1'b0;
        if (op_valid && req.hit) begin
            state_d.wr_valid = 1'b1;
            state_d.wr_sel   = req.dst;
            state_d.wr_data  = res;
            state_d.fz       = res_z;
            state_d.fs       = res_s;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign wr_valid  = state_q.wr_valid;
    assign wr_sel    = state_q.wr_sel;
    assign wr_data   = state_q.wr_data;
    assign flag_zero = state_q.fz;
    assign flag_sign = state_q.fs;
endmodule

// File: rtl/acc_shift_checks.sv
module acc_shift_checks
    import acc_shift_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [15:0]      opcode,
    input logic [ACC_W-1:0] acc0_in,
    input logic [ACC_W-1:0] acc1_in,
    input logic             wr_valid,
    input logic             wr_sel,
    input logic [ACC_W-1:0] wr_data,
    input logic             flag_zero,
    input logic             flag_sign
);
    // R8
    a_r8_flags_match: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (flag_zero == (wr_data == '0)) && (flag_sign == wr_data[ACC_W-1]));

    // R10
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !wr_valid && $stable(flag_zero) && $stable(flag_sign) && $stable(wr_data));

    // R4
    a_r4_left16_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[15:9] == 7'b1111000) |=> wr_valid && wr_data[15:0] == 16'h0);

    a_r4_lright16_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[15:9] == 7'b1111010) |=> wr_valid && wr_data[39:24] == 16'h0);

    a_r4_aright16_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[15:12] == 4'b1001 && opcode[10:8] == 3'b001)
        |=> wr_valid && wr_data[39:23] == {17{wr_data[39]}});

    // R5
    a_r5_zero_count_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 16'h02CA && acc1_in[31:16] == 16'h0)
        |=> wr_valid && !wr_sel && wr_data == $past(acc0_in));

    // R6
    a_r6_dest_ac1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[15:9] == 7'b0011110 && opcode[7:0] == 8'hC0) |=> wr_valid && wr_sel);
endmodule

bind acc_shift_unit acc_shift_checks u_acc_shift_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .opcode    (opcode),
    .acc0_in   (acc0_in),
    .acc1_in   (acc1_in),
    .wr_valid  (wr_valid),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .flag_zero (flag_zero),
    .flag_sign (flag_sign)
);

// File: tb/test_acc_shift_unit.sv
`timescale 1ns/1ps
module test_acc_shift_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] opcode = '0;
    logic [39:0] acc0_in = '0;
    logic [39:0] acc1_in = '0;
    logic        wr_valid;
    logic        wr_sel;
    logic [39:0] wr_data;
    logic        flag_zero;
    logic        flag_sign;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    logic [39:0] exp_data = '0;
    logic        exp_sel  = 1'b0;
    logic        exp_z    = 1'b0;
    logic        exp_s    = 1'b0;

    always #2.5 clk = ~clk;

    acc_shift_unit i_acc_shift_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .acc0_in(acc0_in), .acc1_in(acc1_in), .wr_valid(wr_valid),
        .wr_sel(wr_sel), .wr_data(wr_data), .flag_zero(flag_zero), .flag_sign(flag_sign)
    );

    function automatic logic [39:0] sh(input logic [39:0] v, input bit left,
                                       input bit arith, input int m);
        if (m >= 40) return (left || !arith) ? 40'h0 : {40{v[39]}};
        if (left)  return v << m;
        if (arith) return 40'($signed(v) >>> m);
        return v >> m;
    endfunction

    function automatic void ref_op(input logic [15:0] op, input logic [39:0] a0,
                                   input logic [39:0] a1, output bit hit,
                                   output bit sel, output logic [39:0] res);
        int f, n, s;
        hit = 1; sel = 0; res = '0;
        if (op[15:9] == 7'b0001010) begin
            sel = op[8];
            f = int'(op[5:0]);
            if (!op[6]) res = sh(sel ? a1 : a0, 1, 0, f);
            else begin
                n = -((f >= 32) ? f - 64 : f);
                res = (n >= 0) ? sh(sel ? a1 : a0, 0, op[7], n) : sh(sel ? a1 : a0, 1, 0, -n);
            end
        end else if (op[15:9] == 7'b1111000) begin
            sel = op[8]; res = sh(sel ? a1 : a0, 1, 0, 16);
        end else if (op[15:9] == 7'b1111010) begin
            sel = op[8]; res = sh(sel ? a1 : a0, 0, 0, 16);
        end else if (op[15:12] == 4'b1001 && op[10:8] == 3'b001) begin
            sel = op[11]; res = sh(sel ? a1 : a0, 0, 1, 16);
        end else if (op == 16'h02CA || op == 16'h02CB) begin
            s = int'($signed(a1[31:16]));
            sel = 0;
            res = (s >= 0) ? sh(a0, 0, op[0], s) : sh(a0, 1, 0, -s);
        end else if (op[15:9] == 7'b0011110 && op[7:0] == 8'hC0) begin
            s = int'($signed(a0[31:16]));
            sel = 1;
            res = (s >= 0) ? sh(a1, 1, 0, s) : sh(a1, 0, 0, -s);
        end else hit = 0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit vld, input logic [15:0] op, input logic [39:0] a0,
                          input logic [39:0] a1, input string req);
        bit hit, sel;
        logic [39:0] res;
        ref_op(op, a0, a1, hit, sel, res);
        op_valid = vld; opcode = op; acc0_in = a0; acc1_in = a1;
        @(posedge clk);
        @(negedge clk);
        if (vld && hit) begin
            exp_data = res; exp_sel = sel;
            exp_z = (res == 0); exp_s = res[39];
        end
        check(wr_valid == (vld && hit), {req, " R9 valid"}, 64'(wr_valid), 64'(vld && hit));
        check(wr_data == exp_data, {req, " data"}, 64'(wr_data), 64'(exp_data));
        check(wr_sel == exp_sel, {req, " R9 sel"}, 64'(wr_sel), 64'(exp_sel));
        check(flag_zero == exp_z && flag_sign == exp_s, {req, " R8 flags"},
              64'({flag_zero, flag_sign}), 64'({exp_z, exp_s}));
    endtask

    function automatic logic [39:0] rnd40();
        return {8'($urandom), $urandom};
    endfunction

    function automatic logic [39:0] with_mid(input logic [39:0] v, input logic [15:0] m);
        logic [39:0] r = v;
        r[31:16] = m;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!wr_valid && wr_data == 0 && !flag_zero && !flag_sign && !wr_sel, "R1 reset",
              64'({wr_valid, wr_sel, flag_zero, flag_sign}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_valid && wr_data == 0, "R1 after reset", 64'(wr_data), 64'h0);

        // R2 immediate left, including count >= 40 (R7)
        run_op(1, 16'h1405, 40'h00_0000_1234, 40'h0, "R2 lsl 5");
        run_op(1, 16'h15BF, 40'h0, 40'hFF_FFFF_FFFF, "R2 asl 63 R7");
        run_op(1, 16'h1427, 40'h80_0000_0001, 40'h0, "R2 lsl 39");
        // R3 immediate right, negated field
        run_op(1, 16'h147F, 40'h80_0000_0000, 40'h0, "R3 lsr by 1");
        run_op(1, 16'h15FF, 40'h0, 40'h80_0000_0000, "R3 asr by 1");
        run_op(1, 16'h14E0, 40'h80_1234_5678, 40'h0, "R3 asr by 32");
        run_op(1, 16'h1460, 40'h80_1234_5678, 40'h0, "R3 lsr by 32");
        run_op(1, 16'h1441, 40'h00_0000_0003, 40'h0, "R3 reversed left 1");
        run_op(1, 16'h14C0, 40'h9A_0000_0001, 40'h0, "R3 asr by 0");
        // R4 fixed shifts
        run_op(1, 16'hF000, 40'hAB_CDEF_1234, 40'h0, "R4 lsl16");
        run_op(1, 16'hF500, 40'h0, 40'h9F_0000_0000, "R4 lsr16");
        run_op(1, 16'h9900, 40'h0, 40'h9F_0000_0000, "R4 asr16 ac1");
        run_op(1, 16'h9100, 40'h9F_0000_0000, 40'h0, "R4 asr16 ac0");
        // R5 register driven on ac0
        run_op(1, 16'h02CA, 40'h85_5555_AAAA, with_mid(40'h0, 16'h0000), "R5 zero count");
        run_op(1, 16'h02CB, 40'h85_5555_AAAA, with_mid(40'h0, 16'h0027), "R5 asr 39");
        run_op(1, 16'h02CB, 40'h85_5555_AAAA, with_mid(40'h0, 16'h0028), "R5 asr 40 R7");
        run_op(1, 16'h02CA, 40'h85_5555_AAAA, with_mid(40'h0, 16'h0028), "R5 lsr 40 R7");
        run_op(1, 16'h02CA, 40'h00_0000_0001, with_mid(40'h0, 16'hFFD9), "R5 neg -> left 39");
        run_op(1, 16'h02CB, 40'h00_0000_0001, with_mid(40'h0, 16'h8000), "R5 -32768 R7");
        // R6 reversed form, opcode[8] ignored
        run_op(1, 16'h3CC0, with_mid(40'h0, 16'h0004), 40'h00_0000_00F0, "R6 left 4 d0");
        run_op(1, 16'h3DC0, with_mid(40'h0, 16'hFFFC), 40'h80_0000_0000, "R6 right 4 d1");
        run_op(1, 16'h3DC0, with_mid(40'h0, 16'hFFD8), 40'hFF_FFFF_FFFF, "R6 right 40 R7");
        // R10 ignored
        run_op(0, 16'hF000, 40'h12_3456_789A, 40'h0, "R10 op_valid low");
        run_op(1, 16'h1234, 40'h12_3456_789A, 40'h0, "R10 unknown opcode");
        run_op(1, 16'h02CC, 40'h12_3456_789A, 40'h0, "R10 near opcode");

        for (int k = 0; k < 4000; k++) begin
            logic [15:0] op;
            logic [39:0] a0 = rnd40();
            logic [39:0] a1 = rnd40();
            int kind = int'($urandom_range(0, 6));
            if ($urandom_range(0, 1) == 1) a0 = with_mid(a0, 16'($signed(int'($urandom_range(0, 100)) - 50)));
            if ($urandom_range(0, 1) == 1) a1 = with_mid(a1, 16'($signed(int'($urandom_range(0, 100)) - 50)));
            case (kind)
                0: op = {7'b0001010, 9'($urandom)};
                1: op = {7'b1111000, 1'($urandom), 8'($urandom)};
                2: op = {7'b1111010, 1'($urandom), 8'($urandom)};
                3: op = {4'b1001, 1'($urandom), 3'b001, 8'($urandom)};
                4: op = 16'h02CA | 16'($urandom_range(0, 1));
                5: op = {7'b0011110, 1'($urandom), 8'hC0};
                default: op = 16'($urandom);
            endcase
            run_op($urandom_range(0, 7) != 0, op, a0, a1, "R2-mix random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule